// File: doc/BRIEF.md
# Frame Interrupt Coalescer

This block sits between the per-frame completion pulses of an Ethernet MAC and the frame interrupt that goes to the processor. One instance serves one direction, either transmit or receive. A single 32-bit configuration word holds an enable flag, a frame-count threshold and a time threshold. While coalescing is active, the block gathers completed frames into a batch. It raises the interrupt as soon as the batch reaches the count threshold or the batch timer reaches the time threshold, whichever happens first.

The timer counts units of 64 pulses of `line_tick`, the clock enable of the interface clock. The timer starts with the first frame of a batch and does not run while no frame is pending. Software acknowledges the interrupt with `irq_ack`. The acknowledge clears the batch. Writing a new configuration word also restarts the batch. When coalescing is off, every frame pulse raises the interrupt directly. All pins are plain control and status signals. The block has no streaming data path, so no valid/ready handshake or back-pressure applies.

Top module: `frame_irq_coalescer`

## Requirements
- R1: After reset `cfg_rdata` reads 0x8200_0300, which encodes coalescing enabled, a count threshold of 16 and a time threshold of 768 units. After reset `irq` is 0.
- R2: A write with `cfg_we` stores all 32 bits of `cfg_wdata`, and they read back on `cfg_rdata` from the next cycle on. Bit 31 is the enable, bits [28:21] are the count threshold and bits [15:0] are the time threshold.
- R3: If bit 31 is 0, or the count field is 0, or the time field is 0, coalescing is off. In that case `irq` is 1 in the cycle after any `frame_done` pulse.
- R4: With coalescing on, `irq` rises in the cycle after the frame that brings the pending count to the count threshold.
- R5: A count threshold of 1 raises `irq` in the cycle after every frame, the same as coalescing off.
- R6: One time unit ends on every 64th `line_tick` pulse, counted by a free-running prescaler. The batch timer advances by one unit only while at least one frame was already pending. `irq` rises once the timer reaches the time threshold.
- R7: With coalescing on and no frame pending, `irq` never rises and the timer stays at zero, whatever `line_tick` does.
- R8: `irq` stays high until `irq_ack`. The acknowledge empties the batch and clears the timer. A frame in the same cycle as the acknowledge becomes the first frame of the next batch.
- R9: A configuration write empties the batch and clears the timer, but does not drop an `irq` that is already high. A frame in the write cycle becomes the first frame of the next batch and is judged against the old settings.
- R10: The pending count saturates at 255 and the timer saturates at 65535. Neither wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word to write |
| cfg_rdata | output | 32 | Current configuration word |
| frame_done | input | 1 | One pulse per completed frame |
| line_tick | input | 1 | Interface clock enable |
| irq_ack | input | 1 | Software acknowledge of the interrupt |
| irq | output | 1 | Frame interrupt, held until acknowledged |

## Verification
The assertions check every cycle that:
- the interrupt holds until acknowledged;
- an acknowledge or a configuration write without a frame empties the batch;
- the timer is never non-zero without a pending frame;
- the count stays saturated;
- bypass mode reacts to every frame;
- a unit tick only occurs on a line tick.

Only the bench scenarios can show which cycle the interrupt rises in under a given count or time threshold, or under both competing. They also show that the prescaler phase sets when the first unit ends, and that a frame in an acknowledge or write cycle starts the next batch.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int CFG_W    = 32;
  localparam int EN_BIT   = 31;
  localparam int CNT_LSB  = 21;
  localparam int CNT_W    = 8;
  localparam int TIME_LSB = 0;
  localparam int TIME_W   = 16;
  localparam int PRE_W    = 6;
  localparam logic [CFG_W-1:0] CFG_RESET = 32'h8200_0300;

  typedef struct packed {
    logic              coalesce;
    logic [CNT_W-1:0]  cnt_thr;
    logic [TIME_W-1:0] time_thr;
  } irqc_cfg_t;

  function automatic irqc_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    irqc_cfg_t c;
    c.cnt_thr  = w[CNT_LSB +: CNT_W];
    c.time_thr = w[TIME_LSB +: TIME_W];
    c.coalesce = w[EN_BIT] && (c.cnt_thr != '0) && (c.time_thr != '0);
    return c;
  endfunction
endpackage

// File: rtl/irqc_cfg_reg.sv
module irqc_cfg_reg
  import irqc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CFG_W-1:0] word_o,
  output irqc_cfg_t        cfg_o
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    word_q <= CFG_RESET;
    else if (we_i) word_q <= wdata_i;
  end

  assign word_o = word_q;
  assign cfg_o  = decode_cfg(word_q);

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(word_q));
endmodule

// File: rtl/irqc_prescaler.sv
module irqc_prescaler #(
  parameter int PRE_W = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_tick_i,
  output logic unit_tick_o
);
  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (!rst_n)           pre_q <= '0;
    else if (line_tick_i) pre_q <= pre_q + 1'b1;
  end

  assign unit_tick_o = line_tick_i && (&pre_q);

  // R6
  unit_on_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_tick_o |-> line_tick_i);
endmodule

// File: rtl/irqc_batch.sv
module irqc_batch #(
  parameter int CNT_W  = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              coalesce_i,
  input  logic [CNT_W-1:0]  cnt_thr_i,
  input  logic [TIME_W-1:0] time_thr_i,
  input  logic              frame_i,
  input  logic              unit_tick_i,
  input  logic              restart_i,
  input  logic              ack_i,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0]  CNT_MAX  = '1;
  localparam logic [TIME_W-1:0] TIME_MAX = '1;

  logic [CNT_W-1:0]  cnt_q, cnt_base, cnt_d;
  logic [TIME_W-1:0] units_q, units_base, units_d;
  logic              irq_q, hit;

  always_comb begin
    cnt_base   = restart_i ? '0 : cnt_q;
    units_base = restart_i ? '0 : units_q;
    cnt_d      = cnt_base;
    if (frame_i && cnt_base != CNT_MAX) cnt_d = cnt_base + 1'b1;
    units_d    = units_base;
    if (unit_tick_i && cnt_base != '0 && units_base != TIME_MAX)
      units_d = units_base + 1'b1;
    if (coalesce_i)
      hit = (cnt_d != '0) && ((cnt_d >= cnt_thr_i) || (units_d >= time_thr_i));
    else
      hit = frame_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      units_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      units_q <= units_d;
      irq_q   <= (irq_q && !ack_i) || hit;
    end
  end

  assign irq_o = irq_q;

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !ack_i |=> irq_q);
  // R8
  ack_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i && !frame_i |=> cnt_q == '0 && units_q == '0);
  // R9
  restart_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i && !frame_i |=> cnt_q == '0 && units_q == '0);
  // R7
  idle_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    units_q != '0 |-> cnt_q != '0);
  // R10
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q == CNT_MAX && !restart_i |=> cnt_q == CNT_MAX);
  // R3
  bypass_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !coalesce_i && frame_i |=> irq_q);
endmodule

// File: rtl/frame_irq_coalescer.sv
module frame_irq_coalescer
  import irqc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  input  logic        frame_done,
  input  logic        line_tick,
  input  logic        irq_ack,
  output logic        irq
);
  irqc_cfg_t cfg;
  logic      unit_tick;

  irqc_cfg_reg u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (cfg_we),
    .wdata_i (cfg_wdata),
    .word_o  (cfg_rdata),
    .cfg_o   (cfg)
  );

  irqc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk         (clk),
    .rst_n       (rst_n),
    .line_tick_i (line_tick),
    .unit_tick_o (unit_tick)
  );

  irqc_batch #(.CNT_W(CNT_W), .TIME_W(TIME_W)) u_batch (
    .clk         (clk),
    .rst_n       (rst_n),
    .coalesce_i  (cfg.coalesce),
    .cnt_thr_i   (cfg.cnt_thr),
    .time_thr_i  (cfg.time_thr),
    .frame_i     (frame_done),
    .unit_tick_i (unit_tick),
    .restart_i   (irq_ack || cfg_we),
    .ack_i       (irq_ack),
    .irq_o       (irq)
  );
endmodule

// File: tb/frame_irq_coalescer_tb.sv
module frame_irq_coalescer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        frame_done = 1'b0;
  logic        line_tick = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // reference state (post-edge values)
  logic [31:0] m_cfg;
  logic [5:0]  m_pre;
  logic [7:0]  m_cnt;
  logic [15:0] m_units;
  logic        m_irq;

  always #5 clk = ~clk;

  frame_irq_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .frame_done(frame_done), .line_tick(line_tick),
    .irq_ack(irq_ack), .irq(irq)
  );

  function automatic logic [31:0] mk_cfg(input bit en, input int cnt, input int tm);
    return {en, 2'b00, 8'(cnt), 5'b00000, 16'(tm)};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One cycle: inputs held over a rising edge, reference advanced per the requirements.
  task automatic step(input bit fr, input bit tk, input bit ak, input bit we,
                      input logic [31:0] wd, input string req);
    bit en, ut, clr, hit;
    logic [7:0]  bc, cn;
    logic [15:0] bu, un;
    frame_done = fr; line_tick = tk; irq_ack = ak; cfg_we = we; cfg_wdata = wd;
    en  = m_cfg[31] && m_cfg[28:21] != 0 && m_cfg[15:0] != 0;        // R3
    ut  = tk && (m_pre == 6'd63);                                    // R6
    clr = ak || we;                                                  // R8 R9
    bc  = clr ? 8'd0 : m_cnt;
    bu  = clr ? 16'd0 : m_units;
    cn  = (fr && bc != 8'hff) ? bc + 8'd1 : bc;                      // R10
    un  = (ut && bc != 0 && bu != 16'hffff) ? bu + 16'd1 : bu;
    hit = en ? (cn != 0 && (cn >= m_cfg[28:21] || un >= m_cfg[15:0])) : fr;
    @(posedge clk);
    m_irq = (m_irq && !ak) || hit;
    m_cnt = cn; m_units = un;
    if (tk) m_pre = m_pre + 6'd1;
    if (we) m_cfg = wd;
    @(negedge clk);
    check(req, {31'd0, irq}, {31'd0, m_irq});
    check("R2", cfg_rdata, m_cfg);
  endtask

  task automatic phase(input logic [31:0] wd, input int cycles, input int pf,
                       input int pt, input int pa, input string req);
    step(1'b0, 1'b0, 1'b0, 1'b1, wd, "R9");
    for (int i = 0; i < cycles; i++) begin
      bit ak;
      ak = m_irq && ($urandom_range(99) < pa);
      step($urandom_range(99) < pf, $urandom_range(99) < pt, ak, 1'b0, '0, req);
    end
  endtask

  initial begin
    #1_600_000;
    failures++;
    $display("FAIL watchdog expired");
    if (!done) $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240517));
    m_cfg = 32'h8200_0300; m_pre = 0; m_cnt = 0; m_units = 0; m_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", cfg_rdata, 32'h8200_0300);
    check("R1", {31'd0, irq}, 32'd0);

    // R4 default threshold of 16 frames, directed
    for (int i = 0; i < 16; i++) step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4");
    check("R4", {31'd0, irq}, 32'd1);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0, "R8");
    check("R8", {31'd0, irq}, 32'd0);
    // R8 frame in the acknowledge cycle with count threshold 1 refires
    phase(mk_cfg(1, 1, 50), 0, 0, 0, 0, "R5");
    step(1'b1, 1'b0, 1'b0, 1'b0, '0, "R5");
    step(1'b1, 1'b0, 1'b1, 1'b0, '0, "R8");
    check("R8", {31'd0, irq}, 32'd1);
    step(1'b0, 1'b0, 1'b1, 1'b0, '0, "R8");
    // R7 no frames, ticking line, no interrupt
    phase(mk_cfg(1, 4, 2), 3000, 0, 100, 0, "R7");
    check("R7", {31'd0, irq}, 32'd0);
    // R6 single frame, timer expiry
    step(1'b1, 1'b1, 1'b0, 1'b0, '0, "R6");
    for (int i = 0; i < 200; i++) step(1'b0, 1'b1, 1'b0, 1'b0, '0, "R6");
    check("R6", {31'd0, irq}, 32'd1);
    // R3 bypass variants
    phase(mk_cfg(0, 8, 8), 2000, 30, 50, 40, "R3");
    phase(mk_cfg(1, 0, 8), 2000, 30, 50, 40, "R3");
    phase(mk_cfg(1, 8, 0), 2000, 30, 50, 40, "R3");
    // R5 count one
    phase(mk_cfg(1, 1, 1000), 2000, 20, 50, 60, "R5");
    // R10 saturation: no acknowledge, many frames
    phase(mk_cfg(1, 255, 65535), 600, 90, 0, 0, "R10");
    phase(mk_cfg(1, 255, 65535), 0, 0, 0, 0, "R10");
    // R9 write mid batch
    phase(mk_cfg(1, 20, 40), 300, 5, 80, 0, "R9");
    phase(mk_cfg(1, 3, 40), 300, 5, 80, 50, "R9");
    // random configurations
    for (int p = 0; p < 30; p++) begin
      logic [31:0] w;
      w = mk_cfg($urandom_range(9) != 0, $urandom_range(12), $urandom_range(6));
      w[30:29] = 2'($urandom); w[20:16] = 5'($urandom);
      phase(w, 3000, $urandom_range(1, 20), $urandom_range(50, 100),
            $urandom_range(5, 60), "R4");
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule